// File: doc/BRIEF.md
# High-Speed Mode Entry Tracker for a Two-Wire Serial Slave

This block sits at the front of a two-wire serial slave. It cleans the raw clock and data lines with a deglitcher and finds start and stop conditions on the cleaned lines. From these it tracks whether the bus is running at standard/fast speed or at high speed. It also collects the first byte after each start while the bus is slow. When that byte is a high-speed master code of the form `00001xxx`, the block tells the address decoder to skip the byte and keeps the acknowledge released, so the master sees a NACK.

The next repeated start moves the bus to high speed. An `hsEntry` pulse marks that cycle. Further repeated starts keep the bus at high speed, and only a stop brings it back to the slow rate. The deglitcher length follows the mode. Both lengths are parameters counted in system clock cycles: `SLOW_LEN` for slow operation and `FAST_LEN` for high speed. The length only switches on a start or stop, so it never changes in the middle of a byte.

Top module: `hs_mode_tracker`

## Requirements
- R1: After reset, `sclClean` and `sdaClean` are 1, and `busStart`, `busStop`, `hsMode`, `hsEntry`, `fastFilter`, `forceNack` and `ignoreByte` are all 0.
- R2: `busStart` pulses for one cycle when the cleaned data line falls while the cleaned clock is high. `busStop` pulses for one cycle when the cleaned data line rises while the cleaned clock is high.
- R3: At slow speed, the first byte after a start is sampled MSB first on cleaned clock rises. If its bits 7..3 equal `00001`, `ignoreByte` pulses for one cycle and `forceNack` goes to 1. `forceNack` stays at 1 until the next start or stop. `hsMode` stays 0.
- R4: The repeated start that follows a master code raises `hsMode`, and `hsEntry` pulses for one cycle in the same cycle.
- R5: While `hsMode` is 1, further repeated starts keep it at 1 and give no new `hsEntry` pulse.
- R6: A stop clears `hsMode` in the cycle after `busStop`.
- R7: A slow-speed first byte whose bits 7..3 differ from `00001` gives no `ignoreByte` pulse, leaves `forceNack` at 0, and keeps `hsMode` at 0.
- R8: A byte of value `00001xxx` received while `hsMode` is 1 is ordinary data: it gives no `ignoreByte` pulse and no `forceNack`.
- R9: With `fastFilter` at 0, a raw line change that lasts fewer than `SLOW_LEN` cycles never reaches the cleaned output and produces no start or stop.
- R10: With `fastFilter` at 1, a raw change that lasts at least `FAST_LEN` cycles (and fewer than `SLOW_LEN`) reaches the cleaned output.
- R11: `fastFilter` follows `hsMode`. It changes only in the cycle after a `busStart` or `busStop`.
- R12: The master-code range is exact: `0x08` and `0x0F` match, while `0x07` and `0x10` do not.
- R13: A stop after a master code, with no repeated start in between, leaves the bus at slow speed. A later repeated start that follows an ordinary first byte does not enter high speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclRaw | input | 1 | Raw serial clock line |
| sdaRaw | input | 1 | Raw serial data line |
| sclClean | output | 1 | Deglitched serial clock |
| sdaClean | output | 1 | Deglitched serial data |
| busStart | output | 1 | One-cycle start or repeated-start strobe |
| busStop | output | 1 | One-cycle stop strobe |
| hsMode | output | 1 | Bus is in high-speed mode |
| hsEntry | output | 1 | One-cycle pulse when high-speed mode begins |
| fastFilter | output | 1 | Deglitcher uses the short length |
| forceNack | output | 1 | Keep the acknowledge released for the current byte |
| ignoreByte | output | 1 | One-cycle pulse: address decoder must skip this byte |

## Verification
A raw line change held steady reaches the cleaned output `LEN + 2` clock edges after it is sampled: two synchronizer stages, then `LEN` cycles of agreement. `busStart` and `busStop` are combinational and appear in that same cycle. `hsMode`, `hsEntry`, `fastFilter`, `forceNack` and `ignoreByte` follow one edge later. For the first-byte decision, one more edge passes while the eighth bit is counted before those outputs change. The bench keeps a behavioural model that steps forward on each rising edge with the same latencies. It compares every output on each falling edge, away from the edge where the design updates. Scenario checks are taken only after each bus phase has been held longer than the active filter length plus this pipeline depth.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REST,
    ST_MCODE,
    ST_HS
  } busState_t;

  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic latchSel;
    logic selFast;
  } dpCtrl_t;

  localparam int PREFIX_W = 5;
  localparam logic [PREFIX_W-1:0] MCODE_PREFIX = 5'b00001;

endpackage

// File: rtl/hs_line_filter.sv
module hs_line_filter #(
  parameter int SLOW_LEN = 10,
  parameter int FAST_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic useFast,
  output logic cleanOut
);
  localparam int MAX_LEN = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [1:0]       syncQ;
  logic             cleanQ;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = useFast ? CNT_W'(FAST_LEN - 1) : CNT_W'(SLOW_LEN - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      cleanQ <= 1'b1;
      runCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != cleanQ) begin
        if (runCnt >= limit) begin
          cleanQ <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign cleanOut = cleanQ;
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int SLOW_LEN  = 10,
  parameter int FAST_LEN  = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRaw,
  input  logic    sdaRaw,
  input  dpCtrl_t ctrl,
  output logic    sclClean,
  output logic    sdaClean,
  output logic    startEv,
  output logic    stopEv,
  output logic    sclRise,
  output logic    byteReady,
  output logic    byteIsMcode,
  output logic    fastSel
);
  localparam int LANES = 2;
  localparam int BIT_W = $clog2(BYTE_BITS + 1);

  logic [LANES-1:0] rawLines;
  logic [LANES-1:0] cleanLines;
  logic             fastQ;
  logic             prevScl;
  logic             prevSda;
  logic [BIT_W-1:0] bitCnt;
  logic [BYTE_BITS-1:0] shiftReg;

  assign rawLines = {sdaRaw, sclRaw};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    hs_line_filter #(
      .SLOW_LEN(SLOW_LEN),
      .FAST_LEN(FAST_LEN)
    ) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[lane]),
      .useFast (fastQ),
      .cleanOut(cleanLines[lane])
    );
  end

  assign sclClean = cleanLines[0];
  assign sdaClean = cleanLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
      fastQ   <= 1'b0;
    end else begin
      prevScl <= sclClean;
      prevSda <= sdaClean;
      if (ctrl.latchSel) fastQ <= ctrl.selFast;
    end
  end

  always_comb begin
    startEv = sclClean & prevScl & prevSda & ~sdaClean;
    stopEv  = sclClean & prevScl & ~prevSda & sdaClean;
    sclRise = sclClean & ~prevScl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctrl.clrBits) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctrl.shiftEn) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaClean};
    end
  end

  assign byteReady   = (bitCnt == BIT_W'(BYTE_BITS));
  assign byteIsMcode = (shiftReg[BYTE_BITS-1 -: PREFIX_W] == MCODE_PREFIX);
  assign fastSel     = fastQ;
endmodule

// File: rtl/hs_control.sv
module hs_control
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startEv,
  input  logic    stopEv,
  input  logic    sclRise,
  input  logic    byteReady,
  input  logic    byteIsMcode,
  output dpCtrl_t ctrl,
  output logic    hsMode,
  output logic    hsEntry,
  output logic    forceNack,
  output logic    ignoreByte
);
  busState_t state, nextState;
  logic      nackQ, nackD;
  logic      entryQ, entryD;
  logic      ignQ, ignD;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    nackD     = nackQ;
    entryD    = 1'b0;
    ignD      = 1'b0;
    if (stopEv) begin
      nextState     = ST_IDLE;
      nackD         = 1'b0;
      ctrl.latchSel = 1'b1;
      ctrl.selFast  = 1'b0;
    end else if (startEv) begin
      ctrl.clrBits  = 1'b1;
      ctrl.latchSel = 1'b1;
      nackD         = 1'b0;
      if (state == ST_MCODE || state == ST_HS) begin
        nextState    = ST_HS;
        ctrl.selFast = 1'b1;
        entryD       = (state == ST_MCODE);
      end else begin
        nextState    = ST_ADDR;
        ctrl.selFast = 1'b0;
      end
    end else if (state == ST_ADDR) begin
      if (byteReady) begin
        if (byteIsMcode) begin
          nextState = ST_MCODE;
          nackD     = 1'b1;
          ignD      = 1'b1;
        end else begin
          nextState = ST_REST;
        end
      end else if (sclRise) begin
        ctrl.shiftEn = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nackQ  <= 1'b0;
      entryQ <= 1'b0;
      ignQ   <= 1'b0;
    end else begin
      state  <= nextState;
      nackQ  <= nackD;
      entryQ <= entryD;
      ignQ   <= ignD;
    end
  end

  assign hsMode     = (state == ST_HS);
  assign hsEntry    = entryQ;
  assign forceNack  = nackQ;
  assign ignoreByte = ignQ;
endmodule

// File: rtl/hs_mode_tracker.sv
module hs_mode_tracker
  import hs_pkg::*;
#(
  parameter int SLOW_LEN  = 10,
  parameter int FAST_LEN  = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclClean,
  output logic sdaClean,
  output logic busStart,
  output logic busStop,
  output logic hsMode,
  output logic hsEntry,
  output logic fastFilter,
  output logic forceNack,
  output logic ignoreByte
);
  dpCtrl_t ctrl;
  logic    sclRise;
  logic    byteReady;
  logic    byteIsMcode;

  hs_datapath #(
    .SLOW_LEN (SLOW_LEN),
    .FAST_LEN (FAST_LEN),
    .BYTE_BITS(BYTE_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclRaw     (sclRaw),
    .sdaRaw     (sdaRaw),
    .ctrl       (ctrl),
    .sclClean   (sclClean),
    .sdaClean   (sdaClean),
    .startEv    (busStart),
    .stopEv     (busStop),
    .sclRise    (sclRise),
    .byteReady  (byteReady),
    .byteIsMcode(byteIsMcode),
    .fastSel    (fastFilter)
  );

  hs_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startEv    (busStart),
    .stopEv     (busStop),
    .sclRise    (sclRise),
    .byteReady  (byteReady),
    .byteIsMcode(byteIsMcode),
    .ctrl       (ctrl),
    .hsMode     (hsMode),
    .hsEntry    (hsEntry),
    .forceNack  (forceNack),
    .ignoreByte (ignoreByte)
  );
endmodule

// File: rtl/hs_mode_tracker_checker.sv
module hs_mode_tracker_checker (
  input logic clk,
  input logic rstN,
  input logic busStart,
  input logic busStop,
  input logic hsMode,
  input logic hsEntry,
  input logic fastFilter,
  input logic forceNack,
  input logic ignoreByte
);
  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busStart, busStop}));

  assert_skip_implies_nack_R3: assert property (@(posedge clk) disable iff (!rstN)
    ignoreByte |-> (forceNack && !hsMode));

  assert_entry_marks_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    hsEntry |-> (hsMode && !$past(hsMode)));

  assert_rise_has_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> hsEntry);

  assert_hs_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && !busStop) |=> hsMode);

  assert_stop_leaves_hs_R6: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !hsMode);

  assert_filter_moves_on_event_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fastFilter) |-> $past(busStart || busStop));

  assert_filter_tracks_mode_R11: assert property (@(posedge clk) disable iff (!rstN)
    fastFilter == hsMode);
endmodule

bind hs_mode_tracker hs_mode_tracker_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busStart  (busStart),
  .busStop   (busStop),
  .hsMode    (hsMode),
  .hsEntry   (hsEntry),
  .fastFilter(fastFilter),
  .forceNack (forceNack),
  .ignoreByte(ignoreByte)
);

// File: tb/hs_mode_tracker_bench.sv
`timescale 1ns/1ps
module hs_mode_tracker_bench;
  localparam int SLOW = 10;
  localparam int FAST = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRaw = 1'b1;
  logic sdaRaw = 1'b1;
  logic sclClean, sdaClean, busStart, busStop, hsMode, hsEntry;
  logic fastFilter, forceNack, ignoreByte;

  int total = 0;
  int bad = 0;
  int hold = 14;
  int entCnt = 0, ignCnt = 0, stCnt = 0, spCnt = 0, sdaLowCnt = 0;

  always #2.5 clk = ~clk;

  hs_mode_tracker #(.SLOW_LEN(SLOW), .FAST_LEN(FAST)) u_hs_mode_tracker (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .sclClean(sclClean), .sdaClean(sdaClean), .busStart(busStart),
    .busStop(busStop), .hsMode(hsMode), .hsEntry(hsEntry),
    .fastFilter(fastFilter), .forceNack(forceNack), .ignoreByte(ignoreByte)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 first byte, 2 rest, 3 master code seen, 4 high speed
  int s1[2], s2[2], fl[2], rc[2];
  int pS, pD, mMode, bits, sh, mFast, mEnt, mNack, mIgn;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin s1[i] = 1; s2[i] = 1; fl[i] = 1; rc[i] = 0; end
      pS = 1; pD = 1; mMode = 0; bits = 0; sh = 0; mFast = 0; mEnt = 0; mNack = 0; mIgn = 0;
    end else begin
      int len, st, sp, rise, nMode, nBits, nSh, nFast, nEnt, nNack, nIgn;
      int raw[2], nf[2], nc[2];
      raw[0] = sclRaw; raw[1] = sdaRaw;
      len  = mFast ? FAST : SLOW;
      st   = fl[0] && pS && pD && !fl[1];
      sp   = fl[0] && pS && !pD && fl[1];
      rise = fl[0] && !pS;
      nMode = mMode; nBits = bits; nSh = sh; nFast = mFast; nEnt = 0; nNack = mNack; nIgn = 0;
      if (sp) begin
        nMode = 0; nNack = 0; nFast = 0;
      end else if (st) begin
        nBits = 0; nSh = 0; nNack = 0;
        if (mMode == 3 || mMode == 4) begin nMode = 4; nFast = 1; nEnt = (mMode == 3); end
        else begin nMode = 1; nFast = 0; end
      end else if (mMode == 1 && bits == 8) begin
        if ((sh >> 3) == 1) begin nMode = 3; nNack = 1; nIgn = 1; end
        else nMode = 2;
      end else if (mMode == 1 && rise) begin
        nSh = ((sh << 1) | fl[1]) & 255; nBits = bits + 1;
      end
      for (int i = 0; i < 2; i++) begin
        nf[i] = fl[i]; nc[i] = 0;
        if (s2[i] != fl[i]) begin
          if (rc[i] >= len - 1) begin nf[i] = s2[i]; nc[i] = 0; end
          else nc[i] = rc[i] + 1;
        end
      end
      pS = fl[0]; pD = fl[1];
      for (int i = 0; i < 2; i++) begin fl[i] = nf[i]; rc[i] = nc[i]; s2[i] = s1[i]; s1[i] = raw[i]; end
      mMode = nMode; bits = nBits; sh = nSh; mFast = nFast; mEnt = nEnt; mNack = nNack; mIgn = nIgn;
    end
  end

  // per-clock comparison and event counters, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 sclClean", sclClean, fl[0]);
      chk("R9 sdaClean", sdaClean, fl[1]);
      chk("R2 busStart", busStart, fl[0] && pS && pD && !fl[1]);
      chk("R2 busStop", busStop, fl[0] && pS && !pD && fl[1]);
      chk("R4 hsMode", hsMode, mMode == 4);
      chk("R4 hsEntry", hsEntry, mEnt);
      chk("R3 forceNack", forceNack, mNack);
      chk("R3 ignoreByte", ignoreByte, mIgn);
      chk("R11 fastFilter", fastFilter, mFast);
      entCnt += hsEntry; ignCnt += ignoreByte; stCnt += busStart; spCnt += busStop;
      if (!sdaClean) sdaLowCnt++;
    end
  end

  task automatic phase(logic s, logic d);
    @(negedge clk);
    sclRaw = s; sdaRaw = d;
    repeat (hold - 1) @(negedge clk);
  endtask
  task automatic sendStart(); phase(1, 1); phase(1, 0); phase(0, 0); endtask
  task automatic reStart(); phase(0, 1); phase(1, 1); phase(1, 0); phase(0, 0); endtask
  task automatic sendStop(); phase(0, 0); phase(1, 0); phase(1, 1); endtask
  task automatic sendByte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin phase(0, v[i]); phase(1, v[i]); phase(0, v[i]); end
    phase(0, 1); phase(1, 1); phase(0, 1);
  endtask

  initial begin
    int e0, i0, s0, p0, l0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sclClean", sclClean, 1); chk("R1 sdaClean", sdaClean, 1);
    chk("R1 hsMode", hsMode, 0); chk("R1 fastFilter", fastFilter, 0);
    chk("R1 forceNack", forceNack, 0); chk("R1 hsEntry", hsEntry, 0);
    chk("R1 ignoreByte", ignoreByte, 0); chk("R1 busStart", busStart, 0);

    // ordinary slow transfer
    s0 = stCnt; i0 = ignCnt;
    sendStart(); chk("R2 start count", stCnt - s0, 1);
    sendByte(8'h98);
    chk("R7 no skip", ignCnt - i0, 0); chk("R7 no nack", forceNack, 0); chk("R7 slow", hsMode, 0);
    p0 = spCnt; sendStop(); chk("R2 stop count", spCnt - p0, 1);

    // master code then high speed
    i0 = ignCnt; e0 = entCnt;
    sendStart(); sendByte(8'h08);
    chk("R3 skip pulse", ignCnt - i0, 1); chk("R3 nack held", forceNack, 1); chk("R3 still slow", hsMode, 0);
    reStart();
    chk("R4 entry pulse", entCnt - e0, 1); chk("R4 hs", hsMode, 1); chk("R11 fast", fastFilter, 1);
    chk("R4 nack released", forceNack, 0);
    hold = 5;
    sendByte(8'h98); reStart();
    chk("R5 still hs", hsMode, 1); chk("R5 no new entry", entCnt - e0, 1);
    i0 = ignCnt; sendByte(8'h0F);
    chk("R8 no skip", ignCnt - i0, 0); chk("R8 no nack", forceNack, 0);
    l0 = sdaLowCnt;
    @(negedge clk); sdaRaw = 0; repeat (3) @(negedge clk); sdaRaw = 1; repeat (10) @(negedge clk);
    chk("R10 short pulse passes", (sdaLowCnt - l0) > 0, 1);
    hold = 14;
    sendStop();
    chk("R6 slow after stop", hsMode, 0); chk("R11 slow filter", fastFilter, 0);

    // short glitch at slow speed while idle
    s0 = stCnt; l0 = sdaLowCnt;
    @(negedge clk); sdaRaw = 0; repeat (5) @(negedge clk); sdaRaw = 1; repeat (20) @(negedge clk);
    chk("R9 glitch blocked", sdaLowCnt - l0, 0); chk("R9 no start", stCnt - s0, 0);

    // master-code range edges and abandoned entry
    i0 = ignCnt; sendStart(); sendByte(8'h07);
    chk("R12 0x07 no skip", ignCnt - i0, 0); sendStop();
    i0 = ignCnt; e0 = entCnt; sendStart(); sendByte(8'h0F);
    chk("R12 0x0F skip", ignCnt - i0, 1); sendStop();
    chk("R13 slow after abandoned code", hsMode, 0); chk("R13 no entry", entCnt - e0, 0);
    i0 = ignCnt; sendStart(); sendByte(8'h10);
    chk("R12 0x10 no skip", ignCnt - i0, 0);
    reStart();
    chk("R13 restart stays slow", hsMode, 0); chk("R13 still no entry", entCnt - e0, 0);
    sendStop();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule